// File: doc/BRIEF.md
# Open-Fault Search Sequencer

This block drives the fine-grain search that locates a single open defect among `N_RES` resources of a routed path that is already known to fail. For each search step it presents a removal mask: one bit per resource, where a set bit means the resource must be excluded when the path is rerouted. The test environment reroutes the path, applies the test and returns a pass/fail result. When the search ends, the block reports the index of the faulty resource.

Three search orders are available. In overlapped mode, step `i` removes every resource whose index has bit `i` set. All `log2(N_RES)` masks are issued back-to-back, and the results may return in any order, each tagged with its step number. The pass bits, taken together, form the faulty index. In linear mode, one resource is removed per step until a step passes. In binary mode, the upper half of the current suspect region is removed. The region then shrinks toward whichever half the result implicates.

The search relies on one rule. A rerouted path that passes clears the kept resources, so the fault lies among those removed. A path that still fails clears the removed resources. A single fault is assumed, and `N_RES` is a power of two, at least 2.

Top module: `open_fault_locator`

## Requirements
- R1: While reset is high, and on the first cycle after it, `mask_valid_o`, `done_o` and `err_o` are 0 and `mask_o` is all zeros.
- R2: In overlapped mode, `mask_valid_o` is high on `log2(N_RES)` consecutive cycles, starting the cycle after start is sampled. The mask on the cycle for step s has bit r set exactly when bit s of r is 1, so each mask removes `N_RES/2` resources. `mask_valid_o` is low on the cycle after the last mask.
- R3: In overlapped mode, a result is a `res_valid_i` pulse carrying `res_step_i` = s and `res_pass_i`, where 1 means pass. Results may arrive in any order. Once all steps have a result and emission has ended, `done_o` rises, and bit s of `fault_idx_o` equals the pass bit of step s (step 0 is the LSB).
- R4: In linear mode, the mask for step k is one-hot with only bit k set. It is valid for one cycle. No further mask is issued until a result arrives. After a failing result, the next mask is valid on the cycle after the result.
- R5: In linear mode, the first passing result, at step k, raises `done_o` with `fault_idx_o` = k and `err_o` = 0.
- R6: In linear mode, if all `N_RES` steps fail, `done_o` and `err_o` both rise.
- R7: In binary mode, the suspect region starts as 0..N_RES-1. Each mask removes the upper half [lo+size/2, lo+size) of the region. A pass moves lo to lo+size/2, and a fail keeps lo; size then halves in either case. When size reaches 1, `done_o` rises with `fault_idx_o` = lo after `log2(N_RES)` results.
- R8: While a search runs, `start_i` is ignored. Results that arrive while none is awaited are also ignored: in linear or binary mode outside the wait for a step, and in any mode once done.
- R9: The `mode_i` encoding is 0 = overlapped, 1 = linear, 2 = binary, and 3 behaves as overlapped.
- R10: `done_o`, `err_o` and `fault_idx_o` hold until the next accepted start. That start clears `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (accepted when idle or done) |
| mode_i | input | 2 | Search order: 0/3 overlapped, 1 linear, 2 binary |
| res_valid_i | input | 1 | Step result strobe |
| res_pass_i | input | 1 | Step result: 1 pass, 0 fail |
| res_step_i | input | log2(N_RES) | Step tag of the result (overlapped mode) |
| mask_o | output | N_RES | Removal mask, bit r set = resource r excluded |
| mask_valid_o | output | 1 | Mask strobe |
| fault_idx_o | output | log2(N_RES) | Index of the faulty resource |
| done_o | output | 1 | Search finished |
| err_o | output | 1 | Linear search found no passing step |

## Verification
A wrong internal state in this block shows up at the ports almost at once. A stale step counter or a bad region bound corrupts the very next mask, which is visible one cycle after the start or the result that produced it. A wrong pass-bit store or a wrong region update moves `fault_idx_o` away from the injected fault when `done_o` rises. The bench models a faulty path: each step's pass bit is the mask bit of the chosen faulty resource. It compares every mask and every final index against this model, which also catches stray restarts and accepted stray results.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    MODE_OVL     = 2'd0,
    MODE_LIN     = 2'd1,
    MODE_BIN     = 2'd2,
    MODE_OVL_ALT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OVL  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  function automatic logic is_ovl(input mode_e m);
    return (m == MODE_OVL) || (m == MODE_OVL_ALT);
  endfunction

endpackage

// File: rtl/ofs_mask_gen.sv
module ofs_mask_gen
  import ofs_pkg::*;
#(
  parameter int unsigned N_RES = 8,
  localparam int unsigned IDX_W = $clog2(N_RES)
) (
  input  mode_e              mode,
  input  logic [IDX_W-1:0]   step,
  input  logic [IDX_W:0]     lo,
  input  logic [IDX_W:0]     size,
  output logic [N_RES-1:0]   mask
);

  logic [IDX_W:0] half;
  logic [IDX_W:0] upper_lo;
  logic [IDX_W:0] upper_hi;

  assign half     = size >> 1;
  assign upper_lo = lo + half;
  assign upper_hi = lo + size;

  for (genvar r = 0; r < N_RES; r++) begin : g_bit
    localparam logic [IDX_W:0] RV = (IDX_W+1)'(r);
    always_comb begin
      unique case (mode)
        MODE_LIN: mask[r] = (RV[IDX_W-1:0] == step);
        MODE_BIN: mask[r] = (RV >= upper_lo) && (RV < upper_hi);
        default:  mask[r] = RV[step];
      endcase
    end
  end

endmodule

// File: rtl/ofs_result_bank.sv
module ofs_result_bank #(
  parameter int unsigned STEPS = 3,
  localparam int unsigned TAG_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             pass,
  input  logic [TAG_W-1:0] tag,
  output logic [STEPS-1:0] pass_vec,
  output logic             all_seen
);

  logic [STEPS-1:0] seen_q;

  for (genvar s = 0; s < STEPS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        seen_q[s]   <= 1'b0;
        pass_vec[s] <= 1'b0;
      end else if (en && (32'(tag) == s)) begin
        seen_q[s]   <= 1'b1;
        pass_vec[s] <= pass;
      end
    end
  end

  assign all_seen = &seen_q;

endmodule

// File: rtl/open_fault_locator.sv
module open_fault_locator
  import ofs_pkg::*;
#(
  parameter int unsigned N_RES = 8,
  localparam int unsigned IDX_W = $clog2(N_RES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              res_valid_i,
  input  logic              res_pass_i,
  input  logic [IDX_W-1:0]  res_step_i,
  output logic [N_RES-1:0]  mask_o,
  output logic              mask_valid_o,
  output logic [IDX_W-1:0]  fault_idx_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [IDX_W-1:0] LAST_OVL = IDX_W'(IDX_W - 1);
  localparam logic [IDX_W-1:0] LAST_LIN = IDX_W'(N_RES - 1);
  localparam logic [IDX_W:0]   FULL     = (IDX_W+1)'(N_RES);
  localparam logic [IDX_W:0]   ONE      = (IDX_W+1)'(1);
  localparam int unsigned      TAG_W    = (IDX_W > 1) ? $clog2(IDX_W) : 1;

  state_e           state_q;
  mode_e            mode_q;
  mode_e            mode_in;
  logic [IDX_W-1:0] step_q;
  logic [IDX_W:0]   lo_q;
  logic [IDX_W:0]   size_q;
  logic [IDX_W:0]   half;
  logic [IDX_W:0]   bin_lo_n;
  logic             start_ok;

  mode_e            g_mode;
  logic [IDX_W-1:0] g_step;
  logic [IDX_W:0]   g_lo;
  logic [IDX_W:0]   g_size;
  logic [N_RES-1:0] g_mask;

  logic [IDX_W-1:0] ovl_pass;
  logic             ovl_all;
  logic             ovl_en;
  logic             tag_ok;

  assign mode_in  = mode_e'(mode_i);
  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign half     = size_q >> 1;
  assign bin_lo_n = res_pass_i ? (lo_q + half) : lo_q;

  // next-step parameters feeding the mask generator
  always_comb begin
    g_mode = mode_q;
    g_step = step_q;
    g_lo   = lo_q;
    g_size = size_q;
    if (start_ok) begin
      g_mode = mode_in;
      g_step = '0;
      g_lo   = '0;
      g_size = FULL;
    end else if (state_q == ST_OVL) begin
      g_step = step_q + 1'b1;
    end else if (state_q == ST_WAIT) begin
      g_step = step_q + 1'b1;
      g_lo   = bin_lo_n;
      g_size = half;
    end
  end

  ofs_mask_gen #(.N_RES(N_RES)) u_gen (
    .mode (g_mode),
    .step (g_step),
    .lo   (g_lo),
    .size (g_size),
    .mask (g_mask)
  );

  assign tag_ok = (32'(res_step_i) < IDX_W);
  assign ovl_en = (state_q == ST_OVL) && res_valid_i && tag_ok;

  ofs_result_bank #(.STEPS(IDX_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_ok),
    .en       (ovl_en),
    .pass     (res_pass_i),
    .tag      (TAG_W'(res_step_i)),
    .pass_vec (ovl_pass),
    .all_seen (ovl_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_OVL;
      step_q       <= '0;
      lo_q         <= '0;
      size_q       <= FULL;
      mask_o       <= '0;
      mask_valid_o <= 1'b0;
      fault_idx_o  <= '0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            done_o       <= 1'b0;
            err_o        <= 1'b0;
            fault_idx_o  <= '0;
            mode_q       <= mode_in;
            step_q       <= '0;
            lo_q         <= '0;
            size_q       <= FULL;
            mask_o       <= g_mask;
            mask_valid_o <= 1'b1;
            state_q      <= is_ovl(mode_in) ? ST_OVL : ST_WAIT;
          end
        end
        ST_OVL: begin
          if (mask_valid_o) begin
            if (step_q == LAST_OVL) begin
              mask_valid_o <= 1'b0;
            end else begin
              step_q <= step_q + 1'b1;
              mask_o <= g_mask;
            end
          end else if (ovl_all) begin
            done_o      <= 1'b1;
            fault_idx_o <= ovl_pass;
            state_q     <= ST_DONE;
          end
        end
        ST_WAIT: begin
          mask_valid_o <= 1'b0;
          if (res_valid_i) begin
            if (mode_q == MODE_LIN) begin
              if (res_pass_i) begin
                done_o      <= 1'b1;
                fault_idx_o <= step_q;
                state_q     <= ST_DONE;
              end else if (step_q == LAST_LIN) begin
                done_o  <= 1'b1;
                err_o   <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                step_q       <= step_q + 1'b1;
                mask_o       <= g_mask;
                mask_valid_o <= 1'b1;
              end
            end else begin
              lo_q   <= bin_lo_n;
              size_q <= half;
              if (half == ONE) begin
                done_o      <= 1'b1;
                fault_idx_o <= bin_lo_n[IDX_W-1:0];
                state_q     <= ST_DONE;
              end else begin
                step_q       <= step_q + 1'b1;
                mask_o       <= g_mask;
                mask_valid_o <= 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ofs_locator_chk.sv
module ofs_locator_chk #(
  parameter int unsigned N_RES = 8,
  localparam int unsigned IDX_W = $clog2(N_RES)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [N_RES-1:0] mask_o,
  input logic             mask_valid_o,
  input logic [IDX_W-1:0] fault_idx_o,
  input logic             done_o,
  input logic             err_o,
  input logic [1:0]       mode_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mask_valid_o && !done_o && !err_o && mask_o == '0));

  assert_ovl_half_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_valid_o && (mode_q == 2'd0 || mode_q == 2'd3))
      |-> ($countones(mask_o) == N_RES / 2));

  assert_lin_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    (mask_valid_o && mode_q == 2'd1) |-> ($countones(mask_o) == 1));

  assert_bin_span_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_valid_o && mode_q == 2'd2)
      |-> ($countones(mask_o) >= 1 && $countones(mask_o) <= N_RES / 2));

  assert_err_done_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !mask_valid_o);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(fault_idx_o) && $stable(err_o)));

endmodule

bind open_fault_locator ofs_locator_chk #(.N_RES(N_RES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .mask_o       (mask_o),
  .mask_valid_o (mask_valid_o),
  .fault_idx_o  (fault_idx_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .mode_q       (mode_q)
);

// File: tb/open_fault_locator_test.sv
`timescale 1ns/1ps
module open_fault_locator_test;

  localparam int N = 8;
  localparam int L = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic         res_valid_i = 1'b0;
  logic         res_pass_i = 1'b0;
  logic [L-1:0] res_step_i = '0;
  logic [N-1:0] mask_o;
  logic         mask_valid_o;
  logic [L-1:0] fault_idx_o;
  logic         done_o;
  logic         err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  open_fault_locator #(.N_RES(N)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .res_valid_i(res_valid_i), .res_pass_i(res_pass_i), .res_step_i(res_step_i),
    .mask_o(mask_o), .mask_valid_o(mask_valid_o), .fault_idx_o(fault_idx_o),
    .done_o(done_o), .err_o(err_o)
  );

  // entry: [7:6] mode, [2:0] faulty resource
  localparam logic [7:0] VECS [0:8] = '{
    {2'd0, 3'd0, 3'd0}, {2'd0, 3'd0, 3'd5}, {2'd0, 3'd0, 3'd7},
    {2'd1, 3'd0, 3'd0}, {2'd1, 3'd0, 3'd3}, {2'd1, 3'd0, 3'd7},
    {2'd2, 3'd0, 3'd2}, {2'd2, 3'd0, 3'd6}, {2'd3, 3'd0, 3'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input int f, input bit all_fail);
    logic [N-1:0] em;
    int lo, sz, k, guard;
    @(negedge clk);
    start_i = 1'b1; mode_i = m;
    @(negedge clk);
    start_i = 1'b0;
    if (m == 2'd0 || m == 2'd3) begin
      for (int s = 0; s < L; s++) begin
        for (int r = 0; r < N; r++) em[r] = ((r >> s) & 1) != 0;
        check(mask_valid_o == 1'b1, "R2 overlapped mask valid", int'(mask_valid_o), 1);
        check(mask_o == em, "R2 overlapped mask bits (R9 mode)", int'(mask_o), int'(em));
        @(negedge clk);
      end
      check(mask_valid_o == 1'b0, "R2 overlapped mask count", int'(mask_valid_o), 0);
      for (int s = L - 1; s >= 0; s--) begin
        res_valid_i = 1'b1; res_step_i = L'(s);
        res_pass_i  = ((f >> s) & 1) != 0;
        @(negedge clk);
        res_valid_i = 1'b0;
      end
      guard = 0;
      while (!done_o && guard < 10) begin @(negedge clk); guard++; end
      check(done_o == 1'b1, "R3 overlapped done", int'(done_o), 1);
      check(int'(fault_idx_o) == f, "R3 overlapped index", int'(fault_idx_o), f);
      check(err_o == 1'b0, "R3 overlapped no error", int'(err_o), 0);
    end else begin
      lo = 0; sz = N; k = 0; guard = 0;
      while (!done_o && guard < 60) begin
        if (mask_valid_o) begin
          for (int r = 0; r < N; r++)
            em[r] = (m == 2'd1) ? (r == k) : (r >= lo + sz / 2 && r < lo + sz);
          check(mask_o == em, (m == 2'd1) ? "R4 linear mask" : "R7 binary mask",
                int'(mask_o), int'(em));
          res_valid_i = 1'b1;
          res_pass_i  = all_fail ? 1'b0 : em[f];
          @(negedge clk);
          res_valid_i = 1'b0;
          if (m == 2'd2) begin
            if (em[f]) lo = lo + sz / 2;
            sz = sz / 2;
          end
          k++;
        end else begin
          @(negedge clk);
        end
        guard++;
      end
      check(done_o == 1'b1, "R5/R7 search done", int'(done_o), 1);
      if (all_fail) begin
        check(err_o == 1'b1, "R6 linear exhausted error", int'(err_o), 1);
        check(k == N, "R6 linear step count", k, N);
      end else begin
        check(int'(fault_idx_o) == f, (m == 2'd1) ? "R5 linear index" : "R7 binary index",
              int'(fault_idx_o), f);
        check(err_o == 1'b0, "R5 no error", int'(err_o), 0);
        if (m == 2'd2) check(k == L, "R7 binary step count", k, L);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mask_valid_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0 && mask_o == '0,
          "R1 reset state", int'(mask_valid_o) + int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(mask_valid_o == 1'b0 && done_o == 1'b0, "R1 after reset", int'(done_o), 0);

    foreach (VECS[i]) run(VECS[i][7:6], int'(VECS[i][2:0]), 1'b0);

    // R10: result held while idle in done
    repeat (5) @(negedge clk);
    check(done_o == 1'b1 && int'(fault_idx_o) == 4, "R10 hold result", int'(fault_idx_o), 4);

    // R6: no passing step in linear mode
    run(2'd1, 0, 1'b1);
    check(done_o == 1'b1 && err_o == 1'b1, "R10 error held", int'(err_o), 1);

    // R8: start ignored during a linear search; R4 no mask without result
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'd1;
    @(negedge clk);
    check(err_o == 1'b0 && done_o == 1'b0, "R10 start clears flags", int'(err_o), 0);
    check(mask_o == 8'h01 && mask_valid_o, "R4 first linear mask", int'(mask_o), 1);
    mode_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    check(mask_valid_o == 1'b0, "R8 start ignored while busy", int'(mask_valid_o), 0);
    repeat (3) @(negedge clk);
    check(mask_valid_o == 1'b0, "R4 no mask without result", int'(mask_valid_o), 0);
    res_valid_i = 1'b1; res_pass_i = 1'b0;
    @(negedge clk);
    res_valid_i = 1'b0;
    check(mask_valid_o == 1'b1 && mask_o == 8'h02, "R4 next mask after fail (R8 mode kept)",
          int'(mask_o), 2);
    res_valid_i = 1'b1; res_pass_i = 1'b1;
    @(negedge clk);
    res_valid_i = 1'b0;
    check(done_o == 1'b1 && fault_idx_o == 3'd1, "R5 pass at step 1", int'(fault_idx_o), 1);

    // R8: results ignored once done
    res_valid_i = 1'b1; res_pass_i = 1'b0; res_step_i = '0;
    repeat (2) @(negedge clk);
    res_valid_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1 && fault_idx_o == 3'd1 && !mask_valid_o,
          "R8 result ignored when done", int'(fault_idx_o), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule